// File: doc/BRIEF.md
# Paged DMA Address Translation Unit

This block maps a device-side bus address onto a system address using a flat, single-level table of 64-bit entries kept in on-chip storage. Three static configuration inputs set up the window. The first is the page size, given as a shift amount. The second is the bus address where the window begins. The third is how many table entries are live. For every accepted request the unit returns four things: the page-aligned bus address relative to the window start, the translated system address, the in-page offset mask and a two-bit permission code. A fault flag comes with the response when the requested access is not allowed.

Requests and responses each use a valid/ready handshake, and the unit returns its result two cycles after acceptance. A separate table port lets an update engine write entries and read them back, and it works alongside translation traffic. Reset clears the whole table, so every page starts out with no access. A window-size output reports how many bus bytes the configured table covers.

Top module: `dma_xlate_unit`

## Requirements
- R1: The entry used for a request is the one at index (req_addr − cfg_bus_offset) >> cfg_page_shift.
- R2: If req_addr < cfg_bus_offset, or the index is not less than cfg_entry_count (with counts above DEPTH treated as DEPTH), the response carries permission 0, bus address 0, translated address 0 and an offset mask of all ones.
- R3: For an in-range request, the page mask is ~(2^shift − 1). rsp_bus_addr is (req_addr − cfg_bus_offset) AND page mask, and rsp_xlat_addr is the entry AND page mask.
- R4: For an in-range request, rsp_offset_mask is 2^shift − 1, which is the inverse of the page mask.
- R5: rsp_perm is bits [1:0] of the entry. The codes are 0 = no access, 1 = read only, 2 = write only and 3 = read and write.
- R6: Reset clears every table entry to zero and leaves rsp_valid low and req_ready high. After reset, in-range pages translate with permission 0.
- R7: cfg_window_size always equals cfg_entry_count << cfg_page_shift.
- R8: req_access bit 0 requests read and bit 1 requests write. rsp_fault is high, together with rsp_valid, exactly when a requested access bit is missing from rsp_perm. rsp_fault is never high without rsp_valid.
- R9: A request accepted on a rising edge produces rsp_valid after the next rising edge. While rsp_ready is low, the response holds stable and at most one further request is accepted.
- R10: On the table port, tbl_req with tbl_we writes tbl_wdata at tbl_idx. tbl_req without tbl_we returns the entry on tbl_rdata, with tbl_rvalid high, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page_shift | input | SHW | Page size as log2 of bytes |
| cfg_bus_offset | input | AW | Bus address where the window starts |
| cfg_entry_count | input | CW | Number of live table entries |
| cfg_window_size | output | AW | Bytes covered by the window |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | AW | Bus address to translate |
| req_access | input | 2 | Requested access, bit0 read, bit1 write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken this cycle when valid |
| rsp_bus_addr | output | AW | Page-aligned bus address relative to window |
| rsp_xlat_addr | output | AW | Page-aligned system address |
| rsp_offset_mask | output | AW | In-page offset mask |
| rsp_perm | output | 2 | Permission code |
| rsp_fault | output | 1 | Requested access not permitted |
| tbl_req | input | 1 | Table port access |
| tbl_we | input | 1 | Table port write when high |
| tbl_idx | input | IW | Table port entry index |
| tbl_wdata | input | AW | Table port write data |
| tbl_rvalid | output | 1 | Table port read data valid |
| tbl_rdata | output | AW | Table port read data |

## Verification
The bench aims at the edges of the window. It drives an index exactly equal to the entry count, an address one byte below the window start, and page shifts of 0 and 63. A design with an off-by-one limit, or one that wraps the unsigned subtraction, would return a live permission in these cases instead of an all-ones mask. It also runs all four permission codes against every access type, where a mis-decoded code would raise or drop rsp_fault. A stalled response is held while a second request queues behind it, and a design that lets the pipeline overrun would lose or overwrite that response. Finally, a mid-run reset checks that old entries do not survive.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    localparam int ACC_W = 2;

endpackage

// File: rtl/xlt_entry_store.sv
module xlt_entry_store #(
    parameter int EW    = 64,
    parameter int DEPTH = 64,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [EW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_valid,
    output logic [EW-1:0] rd_data,
    input  logic          lk_en,
    input  logic [IW-1:0] lk_idx,
    output logic [EW-1:0] lk_data
);

    typedef struct packed {
        logic          prv;
        logic [EW-1:0] prd;
        logic [EW-1:0] lk;
    } st_t;

    logic [EW-1:0] mem_d [DEPTH];
    logic [EW-1:0] mem_q [DEPTH];
    st_t st_d, st_q;

    always_comb begin
        mem_d = mem_q;
        st_d  = st_q;
        // R10 write path
        if (wr_en && (int'(wr_idx) < DEPTH)) begin
            mem_d[wr_idx] = wr_data;
        end
        st_d.prv = rd_en;
        if (rd_en) begin
            st_d.prd = (int'(rd_idx) < DEPTH) ? mem_q[rd_idx] : '0;
        end
        if (lk_en) begin
            st_d.lk = (int'(lk_idx) < DEPTH) ? mem_q[lk_idx] : '0;
        end
    end

    // R6: reset clears every entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            st_q <= '0;
        end else begin
            mem_q <= mem_d;
            st_q  <= st_d;
        end
    end

    assign rd_valid = st_q.prv;
    assign rd_data  = st_q.prd;
    assign lk_data  = st_q.lk;

endmodule

// File: rtl/xlt_index_calc.sv
module xlt_index_calc #(
    parameter int AW    = 64,
    parameter int DEPTH = 64,
    parameter int SHW   = 6,
    parameter int CW    = 7,
    parameter int IW    = 6
) (
    input  logic [AW-1:0]  addr,
    input  logic [AW-1:0]  base,
    input  logic [SHW-1:0] shift,
    input  logic [CW-1:0]  count,
    output logic [IW-1:0]  idx,
    output logic           in_range,
    output logic [AW-1:0]  page_mask,
    output logic [AW-1:0]  rel_page
);

    logic [AW-1:0] rel;
    logic [AW-1:0] full_idx;
    logic [AW-1:0] limit;

    always_comb begin
        rel       = addr - base;
        full_idx  = rel >> shift;                              // R1
        limit     = (int'(count) > DEPTH) ? AW'(DEPTH) : AW'(count);
        in_range  = (addr >= base) && (full_idx < limit);      // R2
        page_mask = ~((AW'(1) << shift) - AW'(1));             // R3
        rel_page  = rel & page_mask;
        idx       = full_idx[IW-1:0];
    end

endmodule

// File: rtl/xlt_result_form.sv
module xlt_result_form
    import xlt_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic             in_range,
    input  logic [AW-1:0]    entry,
    input  logic [AW-1:0]    rel_page,
    input  logic [AW-1:0]    page_mask,
    input  logic [ACC_W-1:0] access,
    output logic [AW-1:0]    bus_addr,
    output logic [AW-1:0]    xlat_addr,
    output logic [AW-1:0]    off_mask,
    output perm_e            perm,
    output logic             fault
);

    always_comb begin
        if (in_range) begin
            perm      = perm_e'(entry[1:0]);                    // R5
            bus_addr  = rel_page;
            xlat_addr = entry & page_mask;                      // R3
            off_mask  = ~page_mask;                             // R4
        end else begin
            perm      = PERM_NONE;                              // R2
            bus_addr  = '0;
            xlat_addr = '0;
            off_mask  = '1;
        end
        fault = |(access & ~ACC_W'(perm));                      // R8
    end

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
    import xlt_pkg::*;
#(
    parameter int AW    = 64,
    parameter int DEPTH = 64,
    parameter int SHW   = 6,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SHW-1:0] cfg_page_shift,
    input  logic [AW-1:0]  cfg_bus_offset,
    input  logic [CW-1:0]  cfg_entry_count,
    output logic [AW-1:0]  cfg_window_size,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic [1:0]     req_access,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic [AW-1:0]  rsp_bus_addr,
    output logic [AW-1:0]  rsp_xlat_addr,
    output logic [AW-1:0]  rsp_offset_mask,
    output logic [1:0]     rsp_perm,
    output logic           rsp_fault,
    input  logic           tbl_req,
    input  logic           tbl_we,
    input  logic [IW-1:0]  tbl_idx,
    input  logic [AW-1:0]  tbl_wdata,
    output logic           tbl_rvalid,
    output logic [AW-1:0]  tbl_rdata
);

    typedef struct packed {
        logic             v;
        logic             inr;
        logic [AW-1:0]    relp;
        logic [AW-1:0]    pm;
        logic [ACC_W-1:0] acc;
    } s1_t;

    typedef struct packed {
        logic          v;
        logic [AW-1:0] bus;
        logic [AW-1:0] xlat;
        logic [AW-1:0] mask;
        logic [1:0]    perm;
        logic          flt;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } st_t;

    st_t st_d, st_q;

    logic [IW-1:0] ic_idx;
    logic          ic_inr;
    logic [AW-1:0] ic_pm;
    logic [AW-1:0] ic_relp;
    logic [AW-1:0] lk_entry;
    logic [AW-1:0] rf_bus, rf_xlat, rf_mask;
    perm_e         rf_perm;
    logic          rf_flt;
    logic          advance;
    logic          accept;

    xlt_index_calc #(
        .AW(AW), .DEPTH(DEPTH), .SHW(SHW), .CW(CW), .IW(IW)
    ) u_idx (
        .addr      (req_addr),
        .base      (cfg_bus_offset),
        .shift     (cfg_page_shift),
        .count     (cfg_entry_count),
        .idx       (ic_idx),
        .in_range  (ic_inr),
        .page_mask (ic_pm),
        .rel_page  (ic_relp)
    );

    xlt_entry_store #(
        .EW(AW), .DEPTH(DEPTH), .IW(IW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_req && tbl_we),
        .wr_idx   (tbl_idx),
        .wr_data  (tbl_wdata),
        .rd_en    (tbl_req && !tbl_we),
        .rd_idx   (tbl_idx),
        .rd_valid (tbl_rvalid),
        .rd_data  (tbl_rdata),
        .lk_en    (accept),
        .lk_idx   (ic_idx),
        .lk_data  (lk_entry)
    );

    xlt_result_form #(
        .AW(AW)
    ) u_form (
        .in_range  (st_q.s1.inr),
        .entry     (lk_entry),
        .rel_page  (st_q.s1.relp),
        .page_mask (st_q.s1.pm),
        .access    (st_q.s1.acc),
        .bus_addr  (rf_bus),
        .xlat_addr (rf_xlat),
        .off_mask  (rf_mask),
        .perm      (rf_perm),
        .fault     (rf_flt)
    );

    always_comb begin
        st_d      = st_q;
        advance   = !st_q.s2.v || rsp_ready;
        req_ready = !st_q.s1.v || advance;
        accept    = req_valid && req_ready;

        if (advance) begin
            st_d.s2.v    = st_q.s1.v;
            st_d.s2.bus  = rf_bus;
            st_d.s2.xlat = rf_xlat;
            st_d.s2.mask = rf_mask;
            st_d.s2.perm = rf_perm;
            st_d.s2.flt  = st_q.s1.v && rf_flt;
        end

        if (accept) begin
            st_d.s1.v    = 1'b1;
            st_d.s1.inr  = ic_inr;
            st_d.s1.relp = ic_relp;
            st_d.s1.pm   = ic_pm;
            st_d.s1.acc  = req_access;
        end else if (advance) begin
            st_d.s1.v    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid       = st_q.s2.v;
    assign rsp_bus_addr    = st_q.s2.bus;
    assign rsp_xlat_addr   = st_q.s2.xlat;
    assign rsp_offset_mask = st_q.s2.mask;
    assign rsp_perm        = st_q.s2.perm;
    assign rsp_fault       = st_q.s2.flt;
    assign cfg_window_size = AW'(cfg_entry_count) << cfg_page_shift; // R7

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_xlat_addr) && $stable(rsp_perm))); // R9
    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (((rsp_offset_mask + AW'(1)) & rsp_offset_mask) == '0)); // R4
    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (((rsp_bus_addr | rsp_xlat_addr) & rsp_offset_mask) == '0)); // R3
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (&rsp_offset_mask)) |-> (rsp_perm == 2'b00 && rsp_xlat_addr == '0 && rsp_bus_addr == '0)); // R2
    AST_FAULT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid); // R8
    AST_RW_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm == 2'b11) |-> !rsp_fault); // R8

endmodule

// File: tb/dma_xlate_unit_test.sv
`timescale 1ns/1ps
module dma_xlate_unit_test;

    localparam int AW = 64;
    localparam int DEPTH = 64;
    localparam int SHW = 6;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [SHW-1:0] cfg_page_shift = 6'd12;
    logic [AW-1:0]  cfg_bus_offset = '0;
    logic [CW-1:0]  cfg_entry_count = CW'(8);
    logic [AW-1:0]  cfg_window_size;
    logic req_valid = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_access = 2'b00;
    logic rsp_valid, rsp_ready = 1'b1;
    logic [AW-1:0] rsp_bus_addr, rsp_xlat_addr, rsp_offset_mask;
    logic [1:0] rsp_perm;
    logic rsp_fault;
    logic tbl_req = 1'b0, tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [AW-1:0] tbl_wdata = '0;
    logic tbl_rvalid;
    logic [AW-1:0] tbl_rdata;

    int nchk = 0;
    int nfail = 0;
    logic [AW-1:0] model [DEPTH];

    always #4 clk = ~clk;

    dma_xlate_unit #(.AW(AW), .DEPTH(DEPTH), .SHW(SHW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_page_shift(cfg_page_shift), .cfg_bus_offset(cfg_bus_offset),
        .cfg_entry_count(cfg_entry_count), .cfg_window_size(cfg_window_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_access(req_access), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_bus_addr(rsp_bus_addr), .rsp_xlat_addr(rsp_xlat_addr),
        .rsp_offset_mask(rsp_offset_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    task automatic chk(input string rq, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    function automatic void expect_xlate(input logic [AW-1:0] addr, input logic [1:0] acc,
                                         output logic [AW-1:0] bus, output logic [AW-1:0] xl,
                                         output logic [AW-1:0] msk, output logic [1:0] pm,
                                         output logic flt);
        logic [AW-1:0] rel, pgm, ix;
        int lim;
        rel = addr - cfg_bus_offset;
        pgm = ~((64'd1 << cfg_page_shift) - 64'd1);
        ix  = rel >> cfg_page_shift;
        lim = (int'(cfg_entry_count) > DEPTH) ? DEPTH : int'(cfg_entry_count);
        if (addr < cfg_bus_offset || ix >= 64'(lim)) begin
            bus = '0; xl = '0; msk = '1; pm = 2'b00;
        end else begin
            bus = rel & pgm; xl = model[ix[IW-1:0]] & pgm; msk = ~pgm; pm = model[ix[IW-1:0]][1:0];
        end
        flt = |(acc & ~pm);
    endfunction

    task automatic tbl_write(input int idx, input logic [AW-1:0] d);
        @(negedge clk);
        tbl_req = 1'b1; tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_wdata = d;
        @(negedge clk);
        tbl_req = 1'b0; tbl_we = 1'b0;
        model[idx] = d;
    endtask

    task automatic tbl_check(input int idx, input string rq);
        @(negedge clk);
        tbl_req = 1'b1; tbl_we = 1'b0; tbl_idx = IW'(idx);
        @(negedge clk);
        tbl_req = 1'b0;
        chk(rq, "tbl_rvalid", 64'(tbl_rvalid), 64'd1);
        chk(rq, "tbl_rdata", tbl_rdata, model[idx]);
    endtask

    task automatic xlate(input logic [AW-1:0] addr, input logic [1:0] acc, input string rq);
        logic [AW-1:0] eb, ex, em;
        logic [1:0] ep;
        logic ef;
        expect_xlate(addr, acc, eb, ex, em, ep, ef);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_access = acc;
        chk(rq, "req_ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "rsp_valid early", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk("R9", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rq, "bus", rsp_bus_addr, eb);
        chk(rq, "xlat", rsp_xlat_addr, ex);
        chk(rq, "mask", rsp_offset_mask, em);
        chk(rq, "perm", 64'(rsp_perm), 64'(ep));
        chk("R8", "fault", 64'(rsp_fault), 64'(ef));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk("R6", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R6", "req_ready", 64'(req_ready), 64'd1);
        tbl_check(0, "R6");
        tbl_check(63, "R6");
        xlate(64'h0000_3abc, 2'b01, "R6");

        // R7 window size
        chk("R7", "window 8<<12", cfg_window_size, 64'h8000);
        cfg_entry_count = CW'(64); cfg_page_shift = 6'd21;
        #1 chk("R7", "window 64<<21", cfg_window_size, 64'd64 << 21);
        cfg_entry_count = CW'(8); cfg_page_shift = 6'd12;

        // R10 table port
        for (int i = 0; i < 8; i++) tbl_write(i, {$urandom, $urandom});
        for (int i = 0; i < 8; i++) tbl_check(i, "R10");

        // R5 and R8: each permission code with each access type
        for (int p = 0; p < 4; p++) begin
            tbl_write(p, 64'h1234_5678_9abc_d000 | 64'(p));
            for (int a = 0; a < 4; a++) xlate(64'(p) << 12 | 64'h5a5, 2'(a), "R5");
        end

        // R2 boundaries with a nonzero offset
        cfg_bus_offset = 64'h8000_0000;
        xlate(64'h8000_0000 + (64'd8 << 12), 2'b01, "R2");
        xlate(64'h8000_0000 + (64'd7 << 12) + 64'hfff, 2'b10, "R1");
        xlate(64'h7fff_ffff, 2'b01, "R2");
        cfg_entry_count = CW'(DEPTH);
        xlate(64'h8000_0000 + (64'd63 << 12), 2'b11, "R2");
        xlate(64'h8000_0000 + (64'd64 << 12), 2'b11, "R2");

        // R3/R4 extreme shifts
        cfg_page_shift = 6'd0;
        xlate(64'h8000_0000 + 64'd5, 2'b01, "R3");
        cfg_page_shift = 6'd63;
        xlate(64'h8000_0000 + 64'h0000_1234, 2'b01, "R4");
        cfg_page_shift = 6'd12;

        // R1/R3 random
        for (int i = 0; i < DEPTH; i++) tbl_write(i, {$urandom, $urandom});
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] a;
            int sh, ix;
            sh = $urandom_range(0, 24);
            cfg_page_shift = SHW'(sh);
            cfg_entry_count = CW'($urandom_range(1, DEPTH));
            cfg_bus_offset = {$urandom, $urandom} & 64'h0000_ffff_ffff_f000;
            ix = $urandom_range(0, int'(cfg_entry_count) + 3);
            a = cfg_bus_offset + (64'(ix) << sh) + ({$urandom, $urandom} & ((64'd1 << sh) - 1));
            if (($urandom & 15) == 0) a = cfg_bus_offset - 64'(1 + $urandom_range(0, 100));
            xlate(a, 2'($urandom), (n % 2 == 0) ? "R1" : "R3");
        end

        // R9 stall behaviour
        cfg_page_shift = 6'd12; cfg_bus_offset = '0; cfg_entry_count = CW'(8);
        begin
            logic [AW-1:0] ebA, exA, emA, ebB, exB, emB;
            logic [1:0] epA, epB;
            logic efA, efB;
            expect_xlate(64'h1000, 2'b01, ebA, exA, emA, epA, efA);
            expect_xlate(64'h2000, 2'b01, ebB, exB, emB, epB, efB);
            @(negedge clk);
            rsp_ready = 1'b0;
            req_valid = 1'b1; req_addr = 64'h1000; req_access = 2'b01;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            chk("R9", "stall valid", 64'(rsp_valid), 64'd1);
            repeat (3) @(negedge clk);
            chk("R9", "stall hold xlat", rsp_xlat_addr, exA);
            chk("R9", "stall hold valid", 64'(rsp_valid), 64'd1);
            req_valid = 1'b1; req_addr = 64'h2000;
            chk("R9", "second accept ready", 64'(req_ready), 64'd1);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R9", "full ready low", 64'(req_ready), 64'd0);
            chk("R9", "still A", rsp_xlat_addr, exA);
            rsp_ready = 1'b1;
            @(negedge clk);
            chk("R9", "B valid", 64'(rsp_valid), 64'd1);
            chk("R9", "B xlat", rsp_xlat_addr, exB);
            @(negedge clk);
            chk("R9", "drained", 64'(rsp_valid), 64'd0);
        end

        // R6 mid-run reset clears the table
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tbl_check(1, "R6");
        tbl_check(5, "R6");
        xlate(64'h5004, 2'b10, "R6");

        finish_run();
    end

endmodule